// File: doc/BRIEF.md
# Memory-Controller Ready Poller

This block waits until a target's non-volatile memory controller reports that it is ready. It talks to the target through a byte-wide serial transceiver. On each poll it sends one command byte that reads the target's control/status register. It then takes back one response byte and tests a single ready bit in it. Polls go out one after another, and each waits for the previous response, until a response shows the bit set. The wait then ends with a success result.

The wait has a time limit, counted in milliseconds. A down-counter is loaded with `TIMEOUT_MS` when the wait starts. It decrements once on each millisecond tick, whatever the poll rate. When it reaches zero, the wait ends with a failure result. A tick that arrives in the same cycle as the start is discarded, so the first decrement comes one full period later.

Both byte interfaces use valid/ready handshakes. On the command side, the block holds `cmd_valid_o` and `cmd_byte_o` steady until the transceiver raises `cmd_ready_i`. The only exception is a timeout: it withdraws any pending command, and a command taken in the expiry cycle is abandoned. On the response side, the block raises `rsp_ready_o` only while a response is outstanding. So the transceiver can stall either side for as long as it needs. `start_i`, `ms_tick_i`, `done_o` and `success_o` are plain control pins.

Top module: `nvm_ready_poller`

## Requirements
- R1: After reset, `done_o`, `success_o`, `cmd_valid_o` and `rsp_ready_o` are all 0.
- R2: Every command byte equals `OPCODE | STATUS_IDX`. With the defaults (0x80 and 0x00) this is 0x80.
- R3: Once `cmd_valid_o` is raised, it stays 1 and `cmd_byte_o` stays unchanged until a cycle with `cmd_ready_i` high, unless the wait finishes first.
- R4: At most one poll is in flight. After a command is accepted, `cmd_valid_o` stays 0 and `rsp_ready_o` stays 1 until a response byte is accepted.
- R5: A response accepted with bit `READY_BIT` set (default bit 1, value 0x02) makes `done_o` 1 on the next cycle with `success_o` = 1.
- R6: A response accepted with bit `READY_BIT` clear makes `cmd_valid_o` 1 again on the next cycle, with the same command byte.
- R7: The wait fails on the clock edge of the `TIMEOUT_MS`-th tick counted after the start cycle. A tick in the start cycle does not count. After that edge, `done_o` = 1 and `success_o` = 0.
- R8: The timeout count does not depend on how many polls complete or how quickly.
- R9: If a ready response is accepted in the same cycle as the expiring tick, the result is success.
- R10: `done_o` is high for exactly one cycle. `success_o` holds its value from that pulse until the next accepted start, and the start clears it.
- R11: `start_i` is ignored while a wait is in progress. It neither restarts the timeout nor disturbs the pending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a wait (ignored while one is running) |
| ms_tick_i | input | 1 | One-cycle pulse per elapsed millisecond |
| cmd_valid_o | output | 1 | Command byte is offered to the transceiver |
| cmd_ready_i | input | 1 | Transceiver takes the command byte |
| cmd_byte_o | output | 8 | Status-read command byte |
| rsp_valid_i | input | 1 | Transceiver offers a response byte |
| rsp_ready_o | output | 1 | Block accepts the response byte |
| rsp_byte_i | input | 8 | Response byte from the target |
| done_o | output | 1 | One-cycle pulse when the wait ends |
| success_o | output | 1 | 1 = controller ready, 0 = timed out |

## Verification
The bench stalls the command side for several cycles to catch a design that lets the offered byte move or drop before acceptance. It also checks that no second command goes out while a response is outstanding. It sends a tick in the start cycle and polls far faster than the tick rate. A timer that counts the start-cycle tick, or that counts polls, would then finish one tick early or at the wrong time. It also delivers a ready response on exactly the expiring tick, where a design that lets timeout win would report failure. Finally, it pulses start again mid-wait, which a design that reloads the timer would expose by finishing late.

// File: rtl/nvm_poll_pkg.sv
package nvm_poll_pkg;
  typedef enum logic [0:0] {
    LNK_SEND = 1'b0,
    LNK_WAIT = 1'b1
  } link_state_e;
endpackage

// File: rtl/poll_ms_timer.sv
module poll_ms_timer #(
  parameter int TIMEOUT_MS = 20,
  localparam int CW = $clog2(TIMEOUT_MS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CW'(TIMEOUT_MS);
    end else if (run_i && tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = run_i && !load_i && tick_i && (cnt_q == CW'(1));

  // R8: the count only moves down while a wait runs
  a_r8_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/poll_link.sv
module poll_link
  import nvm_poll_pkg::*;
#(
  parameter logic [7:0] CMD_BYTE  = 8'h80,
  parameter int         READY_BIT = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active_i,
  output logic       cmd_valid_o,
  input  logic       cmd_ready_i,
  output logic [7:0] cmd_byte_o,
  input  logic       rsp_valid_i,
  output logic       rsp_ready_o,
  input  logic [7:0] rsp_byte_i,
  output logic       hit_o
);
  link_state_e st_q;
  logic        cmd_fire, rsp_fire;

  assign cmd_valid_o = active_i && (st_q == LNK_SEND);
  assign rsp_ready_o = active_i && (st_q == LNK_WAIT);
  assign cmd_byte_o  = CMD_BYTE;
  assign cmd_fire    = cmd_valid_o && cmd_ready_i;
  assign rsp_fire    = rsp_ready_o && rsp_valid_i;
  assign hit_o       = rsp_fire && rsp_byte_i[READY_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LNK_SEND;
    end else if (!active_i) begin
      st_q <= LNK_SEND;
    end else if (cmd_fire) begin
      st_q <= LNK_WAIT;
    end else if (rsp_fire) begin
      st_q <= LNK_SEND;
    end
  end

  // R4: never offer a command while a response is awaited
  a_r4_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_o && rsp_ready_o));
  // R4: an accepted command is followed by waiting for its response
  a_r4_wait_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && active_i) |=> (!cmd_valid_o));
endmodule

// File: rtl/nvm_ready_poller.sv
module nvm_ready_poller #(
  parameter logic [7:0] OPCODE     = 8'h80,
  parameter logic [7:0] STATUS_IDX = 8'h00,
  parameter int         READY_BIT  = 1,
  parameter int         TIMEOUT_MS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       ms_tick_i,
  output logic       cmd_valid_o,
  input  logic       cmd_ready_i,
  output logic [7:0] cmd_byte_o,
  input  logic       rsp_valid_i,
  output logic       rsp_ready_o,
  input  logic [7:0] rsp_byte_i,
  output logic       done_o,
  output logic       success_o
);
  localparam logic [7:0] CMD_BYTE = OPCODE | STATUS_IDX;

  logic run_q, done_q, success_q;
  logic start_acc, hit, expire, finish;

  assign start_acc = start_i && !run_q;

  poll_ms_timer #(.TIMEOUT_MS(TIMEOUT_MS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (start_acc),
    .run_i    (run_q),
    .tick_i   (ms_tick_i),
    .expire_o (expire)
  );

  poll_link #(.CMD_BYTE(CMD_BYTE), .READY_BIT(READY_BIT)) u_link (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (run_q),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .cmd_byte_o  (cmd_byte_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_ready_o (rsp_ready_o),
    .rsp_byte_i  (rsp_byte_i),
    .hit_o       (hit)
  );

  assign finish = run_q && (hit || expire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      done_q    <= 1'b0;
      success_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (start_acc) begin
        run_q     <= 1'b1;
        success_q <= 1'b0;
      end else if (finish) begin
        run_q     <= 1'b0;
        success_q <= hit;
      end
    end
  end

  assign done_o    = done_q;
  assign success_o = success_q;

  // R10: done lasts a single cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10: result holds between events
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_acc && !finish) |=> $stable(success_o));
  // R9: a ready response wins over a same-cycle expiry
  a_r9_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && hit) |=> (done_o && success_o));
  // R3: an offered command holds until taken
  a_r3_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i && !finish) |=> (cmd_valid_o && $stable(cmd_byte_o)));
  // R7: expiry without a hit reports failure
  a_r7_timeout_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !hit) |=> (done_o && !success_o));
endmodule

// File: tb/nvm_ready_poller_test.sv
module nvm_ready_poller_test;
  localparam int TMO = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, ms_tick_i = 0, cmd_ready_i = 0, rsp_valid_i = 0;
  logic [7:0] rsp_byte_i = 8'h00;
  logic cmd_valid_o, rsp_ready_o, done_o, success_o;
  logic [7:0] cmd_byte_o;
  int errors = 0, checks = 0, cycles = 0;

  always #2.5 clk = ~clk;

  nvm_ready_poller #(.TIMEOUT_MS(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ms_tick_i(ms_tick_i),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_byte_o(cmd_byte_o),
    .rsp_valid_i(rsp_valid_i), .rsp_ready_o(rsp_ready_o), .rsp_byte_i(rsp_byte_i),
    .done_o(done_o), .success_o(success_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_start();
    start_i = 1; step(); start_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 done", done_o, 0);
    chk("R1 success", success_o, 0);
    chk("R1 cmd_valid", cmd_valid_o, 0);
    chk("R1 rsp_ready", rsp_ready_o, 0);
  endtask

  task automatic t_poll_success();
    do_start();
    for (int i = 0; i < 3; i++) begin
      chk("R3 valid held", cmd_valid_o, 1);
      chk("R2 cmd byte", cmd_byte_o, 8'h80);
      step();
    end
    cmd_ready_i = 1; step(); cmd_ready_i = 0;
    chk("R4 no cmd while waiting", cmd_valid_o, 0);
    chk("R4 rsp ready", rsp_ready_o, 1);
    step();
    chk("R4 still waiting", cmd_valid_o, 0);
    rsp_valid_i = 1; rsp_byte_i = 8'hFD; step(); rsp_valid_i = 0;
    chk("R6 repoll", cmd_valid_o, 1);
    chk("R6 repoll byte", cmd_byte_o, 8'h80);
    chk("R6 no done", done_o, 0);
    cmd_ready_i = 1; step(); cmd_ready_i = 0;
    rsp_valid_i = 1; rsp_byte_i = 8'h02; step(); rsp_valid_i = 0;
    chk("R5 done", done_o, 1);
    chk("R5 success", success_o, 1);
    step();
    chk("R10 done pulse", done_o, 0);
    chk("R10 result held", success_o, 1);
    chk("R10 idle cmd", cmd_valid_o, 0);
  endtask

  task automatic t_timeout();
    int ticks = 0;
    ms_tick_i = 1;  // tick in start cycle must not count (R7)
    do_start();
    ms_tick_i = 0;
    chk("R10 success cleared on start", success_o, 0);
    cmd_ready_i = 1; rsp_valid_i = 1; rsp_byte_i = 8'h00;
    while (ticks < TMO) begin
      for (int k = 0; k < 6; k++) begin
        step();
        chk("R8 no early done", done_o, 0);
      end
      ms_tick_i = 1; step(); ms_tick_i = 0; ticks++;
      if (ticks < TMO) chk("R7 no done before last tick", done_o, 0);
    end
    chk("R7 timeout done", done_o, 1);
    chk("R7 timeout result", success_o, 0);
    cmd_ready_i = 0; rsp_valid_i = 0;
    step();
    chk("R10 fail held", success_o, 0);
    chk("R10 done pulse", done_o, 0);
  endtask

  task automatic t_same_cycle();
    do_start();
    cmd_ready_i = 1; step(); cmd_ready_i = 0;
    for (int t = 0; t < TMO - 1; t++) begin
      ms_tick_i = 1; step(); ms_tick_i = 0; step();
    end
    chk("R9 still running", done_o, 0);
    ms_tick_i = 1; rsp_valid_i = 1; rsp_byte_i = 8'h02; step();
    ms_tick_i = 0; rsp_valid_i = 0;
    chk("R9 done", done_o, 1);
    chk("R9 ready wins", success_o, 1);
    step();
  endtask

  task automatic t_start_busy();
    do_start();
    ms_tick_i = 1; step(); ms_tick_i = 0; step();
    ms_tick_i = 1; step(); ms_tick_i = 0;
    start_i = 1; step(); start_i = 0;
    chk("R11 cmd still pending", cmd_valid_o, 1);
    for (int t = 0; t < TMO - 3; t++) begin
      ms_tick_i = 1; step(); ms_tick_i = 0; step();
    end
    chk("R11 not yet done", done_o, 0);
    ms_tick_i = 1; step(); ms_tick_i = 0;
    chk("R11 timeout from first start", done_o, 1);
    chk("R11 result", success_o, 0);
    step();
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1; step();
    t_reset();
    t_poll_success();
    t_timeout();
    t_same_cycle();
    t_start_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule